// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block is a 16-bit timer that counts up on every clock and sits on a byte-wide register bus. It has one input capture channel and one output compare channel. The capture channel watches an external pin and, on an edge of the chosen polarity, copies the counter value into a capture register. The compare channel raises a flag when the counter equals a compare value that software loads. A third flag marks each wrap of the counter.

The three flags sit in a read-only status byte. Software clears a flag in two steps. It first reads the status byte while the flag is set. It then accesses the low data byte that belongs to that flag. A second copy of the counter sits at alias addresses, so software can time intervals without touching the overflow flag. Each counter pair and the capture pair return a coherent 16-bit value when software reads the high byte first. One interrupt request combines the enabled flags.

A reset restarts the counter and clears the interrupt enables. A reset leaves the flags and the capture polarity bit unchanged.

Top module: `cct_timer`

## Requirements
- R1: A read of address 0x13 returns the capture flag in bit 7, the compare flag in bit 6 and the overflow flag in bit 5. Bits 4..0 always read 0.
- R2: The overflow flag becomes 1 on the clock edge where the counter moves from 0xFFFF to 0x0000. It is visible from the following cycle.
- R3: The compare register is written through 0x16 (high byte) and 0x17 (low byte) and reads back at the same addresses. It resets to 0xFFFF. The compare flag becomes 1 on the edge that ends a cycle in which the counter equals the compare register.
- R4: The capture pin passes through a two-stage synchronizer. On an edge of the selected polarity, the counter value present in the third cycle after the pin change is copied into the capture register, which reads at 0x14 (high) and 0x15 (low), and the capture flag becomes 1.
- R5: Bit 0 of the control byte at 0x12 selects the capture polarity: 0 for a falling edge, 1 for a rising edge. An edge of the other polarity neither sets the flag nor changes the capture register. Reset leaves bit 0 unchanged.
- R6: A flag clears only when its low byte is accessed after a status read that saw that flag set. The low bytes are 0x15 read for capture, 0x17 read or write for compare, and 0x19 read for overflow. An access to the low byte without that prior status read leaves the flag set.
- R7: If a flag's set condition occurs in the same cycle as its clearing access, the flag stays set.
- R8: Control bits 7, 6 and 5 enable the capture, compare and overflow flags onto irq, and reset clears them. irq is 1 exactly when some enabled flag is 1.
- R9: The counter reads at 0x18/0x19 and at the aliases 0x1A/0x1B. A read of either high byte latches the low byte for the next low-byte read. A read of 0x1B never clears the overflow flag.
- R10: After a read of 0x14, capture edges are ignored until 0x15 is read.
- R11: A reset leaves the three status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address while bus_rd is high, else 0 |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request from enabled flags |

## Verification
Suppose an arm bit is wrong. Then a flag either outlives its clearing sequence or vanishes after a low-byte access that had no status read before it. This shows in the status byte on the very next read. A wrong compare or wrap detector moves the flag by whole cycles, so the bench reads the status exactly one cycle before and one cycle after the predicted edge. Broken capture timing or hold logic changes the captured 16-bit value by a known offset. This appears on the next capture register read.

// File: rtl/cct_timer_pkg.sv
package cct_timer_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int NFLAG  = 3;

  // flag index order matches status bits 5,6,7
  localparam int FL_OVF = 0;
  localparam int FL_CMP = 1;
  localparam int FL_CAP = 2;
  localparam int STAT_PAD_W = DATA_W - NFLAG;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_CTRL = 8'h12;
  localparam addr_t A_STAT = 8'h13;
  localparam addr_t A_CAPH = 8'h14;
  localparam addr_t A_CAPL = 8'h15;
  localparam addr_t A_OCRH = 8'h16;
  localparam addr_t A_OCRL = 8'h17;
  localparam addr_t A_CNTH = 8'h18;
  localparam addr_t A_CNTL = 8'h19;
  localparam addr_t A_ALTH = 8'h1A;
  localparam addr_t A_ALTL = 8'h1B;

  typedef struct packed {
    logic wr_ctrl;
    logic rd_stat;
    logic rd_caph;
    logic rd_capl;
    logic wr_ocrh;
    logic wr_ocrl;
    logic acc_ocrl;
    logic rd_any_hi;
    logic rd_any_lo;
    logic rd_cntl;
  } dec_t;
endpackage

// File: rtl/cct_rst_sync.sv
module cct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_hi_i,
  input  logic          rd_lo_i,
  output logic [W-1:0]  cnt_o,
  output logic [BW-1:0] lo_view_o,
  output logic          wrap_o
);
  logic [W-1:0]  cnt_q, cnt_d;
  logic [BW-1:0] lat_q, lat_d;
  logic          val_q, val_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    lat_d = lat_q;
    val_d = val_q;
    if (rd_hi_i) begin
      lat_d = cnt_q[BW-1:0];
      val_d = 1'b1;
    end else if (rd_lo_i) begin
      val_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= '0;
      val_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
      val_q <= val_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign lo_view_o = val_q ? lat_q : cnt_q[BW-1:0];
  assign wrap_o    = &cnt_q;
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_i,
  input  logic         hold_set_i,
  input  logic         hold_clr_i,
  output logic [W-1:0] cap_o,
  output logic         evt_o,
  output logic         hold_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sync_q, sync_d;
  logic            s_new, s_old, edge_seen;
  logic            hold_q, hold_d;
  logic [W-1:0]    cap_q, cap_d;

  always_comb begin
    sync_d    = {sync_q[STAGES-1:0], pin_i};
    s_new     = sync_q[STAGES-1];
    s_old     = sync_q[STAGES];
    edge_seen = pol_i ? (s_new & ~s_old) : (~s_new & s_old);
    evt_o     = edge_seen & ~hold_q;
    hold_d    = hold_q;
    if (hold_set_i)      hold_d = 1'b1;
    else if (hold_clr_i) hold_d = 1'b0;
    cap_d = evt_o ? cnt_i : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hold_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      sync_q <= sync_d;
      hold_q <= hold_d;
      cap_q  <= cap_d;
    end
  end

  assign cap_o  = cap_q;
  assign hold_o = hold_q;
endmodule

// File: rtl/cct_flags.sv
module cct_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [N-1:0] set_i,
  input  logic         arm_req_i,
  input  logic [N-1:0] clr_acc_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] arm_o
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] arm_q, arm_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      // a set in the clearing cycle wins
      flag_d[i] = set_i[i] | (flag_q[i] & ~(clr_acc_i[i] & arm_q[i]));
      arm_d[i]  = arm_q[i];
      if (clr_acc_i[i])                arm_d[i] = 1'b0;
      else if (arm_req_i && flag_q[i]) arm_d[i] = 1'b1;
    end

    // flags survive reset: no reset term, frozen while not running
    always_ff @(posedge clk) begin
      if (run_i) flag_q[i] <= flag_d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q[i] <= 1'b0;
      else        arm_q[i] <= arm_d[i];
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_timer_pkg::*;
#(
  parameter int              SYNC_STAGES = 2,
  parameter int              RST_STAGES  = 2,
  parameter logic [CNT_W-1:0] OCR_RESET  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cap_pin,
  output logic              irq
);
  logic              rst_sync_n;
  dec_t              dec;
  logic [NFLAG-1:0]  en_q, en_d;
  logic              pol_q, pol_d;
  logic [CNT_W-1:0]  ocr_q, ocr_d;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cnt_lo_view;
  logic              wrap;
  logic [CNT_W-1:0]  cap_val;
  logic              cap_evt;
  logic              cap_hold;
  logic [NFLAG-1:0]  flag_set;
  logic [NFLAG-1:0]  clr_acc;
  logic [NFLAG-1:0]  flag;
  logic [NFLAG-1:0]  arm;
  logic [DATA_W-1:0] rdata_c;

  cct_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // access decode; bus is inert while the block is held in reset
  always_comb begin
    dec           = '0;
    dec.wr_ctrl   = rst_sync_n && bus_wr && (bus_addr == A_CTRL);
    dec.rd_stat   = rst_sync_n && bus_rd && (bus_addr == A_STAT);
    dec.rd_caph   = rst_sync_n && bus_rd && (bus_addr == A_CAPH);
    dec.rd_capl   = rst_sync_n && bus_rd && (bus_addr == A_CAPL);
    dec.wr_ocrh   = rst_sync_n && bus_wr && (bus_addr == A_OCRH);
    dec.wr_ocrl   = rst_sync_n && bus_wr && (bus_addr == A_OCRL);
    dec.acc_ocrl  = rst_sync_n && (bus_rd || bus_wr) && (bus_addr == A_OCRL);
    dec.rd_any_hi = rst_sync_n && bus_rd && ((bus_addr == A_CNTH) || (bus_addr == A_ALTH));
    dec.rd_any_lo = rst_sync_n && bus_rd && ((bus_addr == A_CNTL) || (bus_addr == A_ALTL));
    dec.rd_cntl   = rst_sync_n && bus_rd && (bus_addr == A_CNTL);
  end

  cct_counter #(.W(CNT_W), .BW(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_hi_i   (dec.rd_any_hi),
    .rd_lo_i   (dec.rd_any_lo),
    .cnt_o     (cnt),
    .lo_view_o (cnt_lo_view),
    .wrap_o    (wrap)
  );

  cct_capture #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pin_i      (cap_pin),
    .pol_i      (pol_q),
    .cnt_i      (cnt),
    .hold_set_i (dec.rd_caph),
    .hold_clr_i (dec.rd_capl),
    .cap_o      (cap_val),
    .evt_o      (cap_evt),
    .hold_o     (cap_hold)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FL_OVF] = wrap;
    flag_set[FL_CMP] = (cnt == ocr_q);
    flag_set[FL_CAP] = cap_evt;
    clr_acc          = '0;
    clr_acc[FL_OVF]  = dec.rd_cntl;
    clr_acc[FL_CMP]  = dec.acc_ocrl;
    clr_acc[FL_CAP]  = dec.rd_capl;
  end

  cct_flags #(.N(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_i     (rst_sync_n),
    .set_i     (flag_set),
    .arm_req_i (dec.rd_stat),
    .clr_acc_i (clr_acc),
    .flag_o    (flag),
    .arm_o     (arm)
  );

  // control and compare registers: next state
  always_comb begin
    en_d  = en_q;
    pol_d = bus_wdata[0];
    ocr_d = ocr_q;
    if (dec.wr_ctrl) en_d = bus_wdata[DATA_W-1 -: NFLAG];
    if (dec.wr_ocrh) ocr_d[CNT_W-1 -: DATA_W] = bus_wdata;
    if (dec.wr_ocrl) ocr_d[DATA_W-1:0]        = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q  <= '0;
      ocr_q <= OCR_RESET;
    end else begin
      en_q  <= en_d;
      ocr_q <= ocr_d;
    end
  end

  // polarity survives reset: plain enable flop
  always_ff @(posedge clk) begin
    if (dec.wr_ctrl) pol_q <= pol_d;
  end

  always_comb begin
    rdata_c = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:         rdata_c = {en_q, {(STAT_PAD_W-1){1'b0}}, pol_q};
        A_STAT:         rdata_c = {flag, {STAT_PAD_W{1'b0}}};
        A_CAPH:         rdata_c = cap_val[CNT_W-1 -: DATA_W];
        A_CAPL:         rdata_c = cap_val[DATA_W-1:0];
        A_OCRH:         rdata_c = ocr_q[CNT_W-1 -: DATA_W];
        A_OCRL:         rdata_c = ocr_q[DATA_W-1:0];
        A_CNTH, A_ALTH: rdata_c = cnt[CNT_W-1 -: DATA_W];
        A_CNTL, A_ALTL: rdata_c = cnt_lo_view;
        default:        rdata_c = '0;
      endcase
    end
  end

  assign bus_rdata = rdata_c;
  assign irq       = |(flag & en_q);
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
  import cct_timer_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  ocr_q,
  input logic [NFLAG-1:0]  flag,
  input logic [NFLAG-1:0]  arm,
  input logic [NFLAG-1:0]  clr_acc,
  input logic [NFLAG-1:0]  en_q,
  input logic [CNT_W-1:0]  cap_val,
  input logic              cap_evt,
  input logic              cap_hold
);
  a_r1_status_pad: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr == A_STAT) |-> (bus_rdata[STAT_PAD_W-1:0] == '0));

  a_r2_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt == '1) |=> flag[FL_OVF]);

  a_r3_cmp_on_match: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt == ocr_q) |=> flag[FL_CMP]);

  a_r4_capture_value: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_evt |=> (cap_val == $past(cnt)));

  a_r6_ovf_fall_armed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(flag[FL_OVF]) |-> $past(arm[FL_OVF]));

  a_r6_cap_fall_armed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(flag[FL_CAP]) |-> $past(arm[FL_CAP]));

  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cnt == ocr_q) && clr_acc[FL_CMP] && arm[FL_CMP]) |=> flag[FL_CMP]);

  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_q == '0) |-> !irq);

  a_r9_alias_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && bus_addr == A_ALTL && flag[FL_OVF]) |=> flag[FL_OVF]);

  a_r10_hold_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_hold |=> $stable(cap_val));
endmodule

bind cct_timer cct_timer_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .cnt        (cnt),
  .ocr_q      (ocr_q),
  .flag       (flag),
  .arm        (arm),
  .clr_acc    (clr_acc),
  .en_q       (en_q),
  .cap_val    (cap_val),
  .cap_evt    (cap_evt),
  .cap_hold   (cap_hold)
);

// File: tb/cct_timer_bench.sv
module cct_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_rd;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cap_pin;
  logic       irq;

  int n_checks;
  int n_fail;
  bit done;

  logic [7:0] q_exp[$];
  logic [7:0] q_mask[$];
  string      q_tag[$];

  cct_timer u_cct_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cap_pin   (cap_pin),
    .irq       (irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // monitor: pops the expected item for each read, away from the clock edge
  initial begin
    logic [7:0] e, m;
    string      t;
    forever begin
      @(negedge clk);
      #2;
      if (bus_rd && q_exp.size() > 0) begin
        e = q_exp.pop_front();
        m = q_mask.pop_front();
        t = q_tag.pop_front();
        n_checks++;
        if ((bus_rdata & m) !== (e & m)) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", t, bus_rdata & m, e & m);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input logic [7:0] m,
                        input string tag);
    q_exp.push_back(e);
    q_mask.push_back(m);
    q_tag.push_back(tag);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counter value during the first of the two cycles used
  task automatic peek16(output logic [15:0] v);
    logic [7:0] h, l;
    peek(8'h1A, h);
    peek(8'h1B, l);
    v = {h, l};
  endtask

  task automatic check_irq(input logic e, input string tag);
    #2;
    check(irq === e, tag, int'(irq), int'(e));
  endtask

  initial begin
    logic [15:0] c, v1, v2, t, cx, cold;
    logic [7:0]  h, l;
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; cap_pin = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset state
    rd_chk(8'h12, 8'h00, 8'hE0, "R8 enables after reset");
    check_irq(1'b0, "R8 irq after reset");
    rd_chk(8'h13, 8'h00, 8'h1F, "R1 status pad bits");
    rd_chk(8'h16, 8'hFF, 8'hFF, "R3 compare reset high");
    peek(8'h15, h); peek(8'h17, h); peek(8'h19, h);
    rd_chk(8'h13, 8'h00, 8'hFF, "R6 flags cleared by sequence");

    // R9 coherent read and alias equality
    peek(8'h18, h); peek(8'h19, l);
    v1 = {h, l};
    peek16(v2);
    check(v2 == v1 + 16'd2, "R9 alias tracks counter", int'(v2), int'(v1 + 16'd2));

    // R3 compare match, R7 set beats clear
    peek16(c);                      // cycle a
    t = c + 16'd12;
    wr(8'h16, t[15:8]);             // a+2
    wr(8'h17, t[7:0]);              // a+3
    rd_chk(8'h13, 8'h00, 8'h40, "R3 compare flag not early");   // a+4
    idle(8);                        // to a+13
    rd_chk(8'h13, 8'h40, 8'h40, "R3 compare flag set on match"); // arms
    wr(8'h16, t[15:8] + 8'd1);      // a+14, match moves to a+268
    idle(253);
    rd_chk(8'h17, t[7:0], 8'hFF, "R3 compare low readback");     // a+268
    rd_chk(8'h13, 8'h40, 8'h40, "R7 set wins over clearing access");
    rd_chk(8'h13, 8'h40, 8'h40, "R6 arm compare");
    rd_chk(8'h17, t[7:0], 8'hFF, "R6 compare low access");
    rd_chk(8'h13, 8'h00, 8'h40, "R6 compare flag cleared");

    // R4 rising capture
    wr(8'h12, 8'h01);
    peek16(c);                      // cycle b
    cap_pin = 1'b1;                 // b+2
    idle(3);
    cx = c + 16'd4;
    rd_chk(8'h13, 8'h80, 8'h80, "R4 capture flag set");
    rd_chk(8'h14, cx[15:8], 8'hFF, "R4 capture high");
    rd_chk(8'h15, cx[7:0], 8'hFF, "R4 capture low");
    rd_chk(8'h13, 8'h00, 8'h80, "R6 capture flag cleared");

    // R5 falling edge ignored with rising polarity
    cap_pin = 1'b0;
    idle(5);
    rd_chk(8'h13, 8'h00, 8'h80, "R5 opposite edge sets nothing");
    rd_chk(8'h14, cx[15:8], 8'hFF, "R5 capture high unchanged");
    rd_chk(8'h15, cx[7:0], 8'hFF, "R5 capture low unchanged");

    // R5 falling polarity
    wr(8'h12, 8'h00);
    cap_pin = 1'b1;
    idle(5);
    rd_chk(8'h13, 8'h00, 8'h80, "R5 rising ignored with falling polarity");
    peek16(c);
    cap_pin = 1'b0;
    idle(3);
    cx = c + 16'd4;
    rd_chk(8'h13, 8'h80, 8'h80, "R5 falling edge captured");
    peek(8'h17, h);                 // unrelated low byte, disarms nothing here
    rd_chk(8'h14, cx[15:8], 8'hFF, "R5 falling capture high");
    // low read here: armed by the status read above, clears the flag
    rd_chk(8'h15, cx[7:0], 8'hFF, "R5 falling capture low");
    rd_chk(8'h13, 8'h00, 8'h80, "R6 capture cleared after armed low read");

    // R6 low read without status read
    wr(8'h12, 8'h01);
    cap_pin = 1'b1;
    idle(5);
    peek(8'h14, h);
    peek(8'h15, l);
    cold = {h, l};
    rd_chk(8'h15, cold[7:0], 8'h00, "R6 unarmed low read");
    rd_chk(8'h13, 8'h80, 8'h80, "R6 flag kept without arming");
    rd_chk(8'h15, cold[7:0], 8'hFF, "R6 armed low read");
    rd_chk(8'h13, 8'h00, 8'h80, "R6 flag cleared after arming");

    // R10 capture blocked between high and low reads
    cap_pin = 1'b0;
    idle(4);
    cap_pin = 1'b1;
    rd_chk(8'h14, cold[15:8], 8'hFF, "R10 capture high before hold");
    idle(4);
    rd_chk(8'h15, cold[7:0], 8'hFF, "R10 capture low unchanged");
    rd_chk(8'h13, 8'h00, 8'h80, "R10 no flag while held");

    // R8 interrupt enables
    wr(8'h12, 8'hE1);
    check_irq(1'b0, "R8 irq low with no flag");
    cap_pin = 1'b0;
    idle(4);
    cap_pin = 1'b1;
    idle(4);
    check_irq(1'b1, "R8 irq from capture flag");
    wr(8'h12, 8'h61);
    check_irq(1'b0, "R8 irq masked by capture enable");

    // R11 and R5: reset keeps flags and polarity
    cap_pin = 1'b0;
    idle(4);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rd_chk(8'h12, 8'h01, 8'hFF, "R5 polarity kept over reset, enables cleared");
    rd_chk(8'h13, 8'h80, 8'hE0, "R11 flags kept over reset");
    rd_chk(8'h15, 8'h00, 8'h00, "R11 clear capture flag");

    // R2 overflow and R9 alias read
    peek16(c);                      // cycle f
    idle(int'(16'hFFFF - c) - 2);   // to cycle g, counter at 0xFFFF
    rd_chk(8'h13, 8'h00, 8'h20, "R2 overflow flag not early");
    rd_chk(8'h13, 8'h20, 8'h20, "R2 overflow flag on wrap");
    rd_chk(8'h1B, 8'h01, 8'hFF, "R9 alias low after wrap");
    rd_chk(8'h13, 8'h20, 8'h20, "R9 alias read kept overflow flag");
    rd_chk(8'h19, 8'h03, 8'hFF, "R9 counter low read");
    rd_chk(8'h13, 8'h00, 8'h20, "R6 overflow flag cleared");

    idle(2);
    finish_run();
  end
endmodule